// File: doc/BRIEF.md
# E1 Receive Elastic FIFO with Programmable Latency

This block is the receive-side elastic store for a 2.048 Mbit/s E1 payload stream. Payload bits come in on the recovered line clock and go out on a separate 2.048 MHz serial clock supplied by the terminal side. In FIFO mode each bit stays in the store for a programmed number of whole bytes before it is sent out. Because of this, small phase wander between the two clocks is absorbed and does not corrupt the data.

The read side divides the output into frames of 32 timeslots of 8 bits, 256 bits per frame, with the most significant bit of each timeslot sent first. It reports the position of each outgoing bit. A frame-sync pin can work in either direction. As an output it marks the first bit of every frame. As an input it forces the read frame to line up with an external pulse.

The two clocks are expected to be phase-locked. If they are not, the block does not try to prevent the fault. It latches an over-run or under-run flag, and the flag stays set until it is cleared.

Top module: `e1_elastic_fifo`

## Requirements
- R1: While `arst_n` is low, `ser_bit` is 1 and `fs_out`, `ts_idx`, `bit_idx`, `underrun` and `overrun` are 0. After reset the latency field holds 4, so entering FIFO mode without loading it gives a latency of 4 bytes.
- R2: FIFO mode is active only while `buf_mode` is 2'b10. With any other code, every read edge makes `ser_bit` 1 and makes `fs_out`, `ts_idx`, `bit_idx`, `underrun` and `overrun` 0.
- R3: In FIFO mode, with both clocks at the same rate, every bit on `ser_bit` is the line bit written L write cycles earlier. L is at least 8·D and at most 8·D+6, where D is the depth in bytes and the extra cycles come from pointer synchronisation.
- R4: A `lat_bytes` value of 1 to 31 gives a depth of that many bytes. The value 0 gives 32 bytes, which is one full frame.
- R5: Pulsing `lat_load` in FIFO mode stores `lat_bytes` and moves the read pointer so the new depth applies from that edge. Entering FIFO mode does the same with the stored value. Both actions clear `underrun` and `overrun`.
- R6: With `fs_dir` = 0, `fs_oe` is 1. `bit_idx` counts 0 to 7 (0 is the MSB of the timeslot) and `ts_idx` counts 0 to 31, both starting from 0 on the first read edge in FIFO mode. `fs_out` is a one-cycle pulse that comes with ts 0 / bit 0 and repeats every 256 cycles.
- R7: With `fs_dir` = 1, `fs_oe` is 0 and `fs_out` stays 0. A high `fs_in` at a read edge makes the bit sent at that edge ts 0 / bit 0, and counting continues from there.
- R8: `underrun` is set when the read pointer reaches or passes the synchronised write pointer. It then stays set.
- R9: `overrun` is set when the unread fill exceeds the 512-bit store. It then stays set.
- R10: A `flag_clr` pulse makes `underrun` and `overrun` 0 after that edge. If the fault condition has gone, they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Recovered receive line clock (write side) |
| line_bit | input | 1 | Serial payload bit, captured on the rising edge of `line_clk` |
| ser_clk | input | 1 | 2.048 MHz receive serial clock (read side) |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| buf_mode | input | 2 | Buffer mode select; 2'b10 selects FIFO mode |
| lat_load | input | 1 | Strobe that loads `lat_bytes` and re-centres the read pointer |
| lat_bytes | input | 5 | Latency in bytes; 0 means 32 |
| flag_clr | input | 1 | Strobe that clears both error flags |
| fs_dir | input | 1 | Frame-sync direction: 0 output, 1 input |
| fs_in | input | 1 | Frame-sync input, sampled on `ser_clk` when `fs_dir` = 1 |
| fs_out | output | 1 | Frame-start pulse when `fs_dir` = 0 |
| fs_oe | output | 1 | Output enable for the frame-sync pad |
| ser_bit | output | 1 | Serial payload bit out, launched on `ser_clk` |
| ts_idx | output | 5 | Timeslot number of the bit on `ser_bit` |
| bit_idx | output | 3 | Bit number within the timeslot, 0 = MSB |
| underrun | output | 1 | Sticky under-run flag |
| overrun | output | 1 | Sticky over-run flag |

## Verification
All read-side results are registered. A change on `buf_mode`, `lat_load`, `flag_clr` or `fs_in` during the low phase of `ser_clk` shows on the outputs just after the next rising edge. The bench drives every input on a falling edge and samples one falling edge later. A line bit reaches `ser_bit` 8·D plus two to four cycles after it is written, because of the two synchroniser stages and the output register. The bench therefore records every written bit with its write index and searches for the delay that matches a 64-bit output window, instead of expecting one exact cycle. The flag tests stop or speed up the line clock for a known number of read cycles, so the expected fill at each check is a simple count in write and read cycles.

// File: rtl/e1ef_pkg.sv
package e1ef_pkg;

  typedef enum logic [1:0] {
    BUF_BYPASS = 2'b00,
    BUF_SLIP   = 2'b01,
    BUF_FIFO   = 2'b10,
    BUF_RSVD   = 2'b11
  } buf_mode_e;

  localparam int DEF_STORE_AW = 9;   // 512-bit store
  localparam int DEF_LAT_W    = 5;   // byte latency field width
  localparam int DEF_TS_W     = 5;   // 32 timeslots
  localparam int DEF_BIT_W    = 3;   // 8 bits per timeslot
  localparam int DEF_LAT_RST  = 4;   // bytes after reset

endpackage

// File: rtl/e1ef_rst_sync.sv
module e1ef_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;

endmodule

// File: rtl/e1ef_ptr_sync.sv
module e1ef_ptr_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_out[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ s2_q[i];
    end
  end

endmodule

// File: rtl/e1ef_wr_store.sv
module e1ef_wr_store #(
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          din,
  output logic [AW+1:0] wgray,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_data
);

  localparam int PW    = AW + 2;
  localparam int STORE = 1 << AW;

  logic          mem [STORE];
  logic [PW-1:0] wptr_q, wptr_n;
  logic [PW-1:0] wgray_q, wgray_n;
  logic          wr_en;

  assign wr_en = 1'b1;  // line side writes every recovered clock

  always_comb begin
    wptr_n  = wptr_q;
    if (wr_en) wptr_n = wptr_q + PW'(1);
    wgray_n = wptr_n ^ (wptr_n >> 1);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_n;
      wgray_q <= wgray_n;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wptr_q[AW-1:0]] <= din;
  end

  assign wgray   = wgray_q;
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/e1ef_rd_ctrl.sv
module e1ef_rd_ctrl
  import e1ef_pkg::*;
#(
  parameter int AW      = 9,
  parameter int LAT_W   = 5,
  parameter int TS_W    = 5,
  parameter int BIT_W   = 3,
  parameter int LAT_RST = 4
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             lat_load,
  input  logic [LAT_W-1:0] lat_val,
  input  logic             clr,
  input  logic             fs_dir,
  input  logic             fs_in,
  input  logic [AW+1:0]    wptr,
  input  logic             rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             sbit,
  output logic             fs_pulse,
  output logic [TS_W-1:0]  ts_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             und_o,
  output logic             ovr_o
);

  localparam int            PW         = AW + 2;
  localparam int            POS_W      = TS_W + BIT_W;
  localparam logic [PW-1:0] STORE_BITS = PW'(1) << AW;

  logic              fifo_q, fifo_on, entering, reinit;
  logic [LAT_W-1:0]  lat_q, lat_n, lat_eff;
  logic [LAT_W:0]    depth_bytes;
  logic [PW-1:0]     depth_bits;
  logic [PW-1:0]     rptr_q, rptr_n, rptr_use, fill;
  logic [POS_W-1:0]  pos_q, pos_n, pos_eff;
  logic              realign, under_hit, over_hit, flag_wipe;
  logic              sbit_q, sbit_n, fs_q, fs_n, und_q, und_n, ovr_q, ovr_n;
  logic [TS_W-1:0]   ts_q, ts_n;
  logic [BIT_W-1:0]  bit_q, bit_n;

  // next-state
  always_comb begin
    fifo_on     = (mode == BUF_FIFO);
    entering    = fifo_on & ~fifo_q;
    reinit      = fifo_on & (entering | lat_load);
    lat_eff     = lat_load ? lat_val : lat_q;
    depth_bytes = {(lat_eff == '0), lat_eff};
    depth_bits  = PW'({depth_bytes, 3'b000});
    rptr_use    = reinit ? (wptr - depth_bits) : rptr_q;
    fill        = wptr - rptr_use;
    under_hit   = (fill == '0) | fill[PW-1];
    over_hit    = ~fill[PW-1] & (fill > STORE_BITS);
    realign     = fs_dir & fs_in & (pos_q != '0);
    pos_eff     = realign ? '0 : pos_q;
    flag_wipe   = reinit | clr;

    lat_n = lat_q;
    if (lat_load) lat_n = lat_val;

    if (fifo_on) begin
      rptr_n = rptr_use + PW'(1);
      pos_n  = pos_eff + POS_W'(1);
      sbit_n = rd_data;
      fs_n   = ~fs_dir & (pos_eff == '0);
      ts_n   = pos_eff[POS_W-1:BIT_W];
      bit_n  = pos_eff[BIT_W-1:0];
      und_n  = ~flag_wipe & (und_q | under_hit);
      ovr_n  = ~flag_wipe & (ovr_q | over_hit);
    end else begin
      rptr_n = rptr_q;
      pos_n  = '0;
      sbit_n = 1'b1;
      fs_n   = 1'b0;
      ts_n   = '0;
      bit_n  = '0;
      und_n  = 1'b0;
      ovr_n  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_q <= 1'b0;
      lat_q  <= LAT_W'(LAT_RST);
      rptr_q <= '0;
      pos_q  <= '0;
      sbit_q <= 1'b1;
      fs_q   <= 1'b0;
      ts_q   <= '0;
      bit_q  <= '0;
      und_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      fifo_q <= fifo_on;
      lat_q  <= lat_n;
      rptr_q <= rptr_n;
      pos_q  <= pos_n;
      sbit_q <= sbit_n;
      fs_q   <= fs_n;
      ts_q   <= ts_n;
      bit_q  <= bit_n;
      und_q  <= und_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rd_addr  = rptr_use[AW-1:0];
  assign sbit     = sbit_q;
  assign fs_pulse = fs_q;
  assign ts_o     = ts_q;
  assign bit_o    = bit_q;
  assign und_o    = und_q;
  assign ovr_o    = ovr_q;

endmodule

// File: rtl/e1_elastic_fifo.sv
module e1_elastic_fifo
  import e1ef_pkg::*;
#(
  parameter int STORE_AW = DEF_STORE_AW,
  parameter int LAT_W    = DEF_LAT_W,
  parameter int TS_W     = DEF_TS_W,
  parameter int BIT_W    = DEF_BIT_W,
  parameter int LAT_RST  = DEF_LAT_RST
) (
  input  logic             line_clk,
  input  logic             line_bit,
  input  logic             ser_clk,
  input  logic             arst_n,
  input  logic [1:0]       buf_mode,
  input  logic             lat_load,
  input  logic [LAT_W-1:0] lat_bytes,
  input  logic             flag_clr,
  input  logic             fs_dir,
  input  logic             fs_in,
  output logic             fs_out,
  output logic             fs_oe,
  output logic             ser_bit,
  output logic [TS_W-1:0]  ts_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             underrun,
  output logic             overrun
);

  localparam int PW = STORE_AW + 2;

  logic                wrst_n_s, rrst_n_s;
  logic [PW-1:0]       wgray, wptr_rd;
  logic [STORE_AW-1:0] rd_addr;
  logic                rd_data;

  e1ef_rst_sync u_wrst (.clk(line_clk), .arst_n(arst_n), .srst_n(wrst_n_s));
  e1ef_rst_sync u_rrst (.clk(ser_clk),  .arst_n(arst_n), .srst_n(rrst_n_s));

  e1ef_wr_store #(.AW(STORE_AW)) u_store (
    .wclk    (line_clk),
    .rst_n   (wrst_n_s),
    .din     (line_bit),
    .wgray   (wgray),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  e1ef_ptr_sync #(.W(PW)) u_wsync (
    .clk     (ser_clk),
    .rst_n   (rrst_n_s),
    .gray_in (wgray),
    .bin_out (wptr_rd)
  );

  e1ef_rd_ctrl #(
    .AW(STORE_AW), .LAT_W(LAT_W), .TS_W(TS_W), .BIT_W(BIT_W), .LAT_RST(LAT_RST)
  ) u_rd (
    .rclk     (ser_clk),
    .rst_n    (rrst_n_s),
    .mode     (buf_mode),
    .lat_load (lat_load),
    .lat_val  (lat_bytes),
    .clr      (flag_clr),
    .fs_dir   (fs_dir),
    .fs_in    (fs_in),
    .wptr     (wptr_rd),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .sbit     (ser_bit),
    .fs_pulse (fs_out),
    .ts_o     (ts_idx),
    .bit_o    (bit_idx),
    .und_o    (underrun),
    .ovr_o    (overrun)
  );

  assign fs_oe = ~fs_dir;

endmodule

// File: rtl/e1ef_checker.sv
module e1ef_checker #(
  parameter int TS_W  = 5,
  parameter int BIT_W = 3
) (
  input logic             ser_clk,
  input logic             rst_n,
  input logic [1:0]       buf_mode,
  input logic             fs_dir,
  input logic             fs_in,
  input logic             lat_load,
  input logic             flag_clr,
  input logic             ser_bit,
  input logic             fs_out,
  input logic [TS_W-1:0]  ts_idx,
  input logic [BIT_W-1:0] bit_idx,
  input logic             underrun,
  input logic             overrun
);

  p_idle_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (buf_mode != 2'b10) |=> (ser_bit && !fs_out && ts_idx == '0 && bit_idx == '0
                             && !underrun && !overrun))
    else $error("p_idle_r2");

  p_sync_pos_r6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    fs_out |-> (ts_idx == '0 && bit_idx == '0))
    else $error("p_sync_pos_r6");

  p_sync_width_r6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    fs_out |=> !fs_out)
    else $error("p_sync_width_r6");

  p_sync_quiet_r7: assert property (@(posedge ser_clk) disable iff (!rst_n)
    fs_dir |=> !fs_out)
    else $error("p_sync_quiet_r7");

  p_align_r7: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (buf_mode == 2'b10 && fs_dir && fs_in) |=> (ts_idx == '0 && bit_idx == '0))
    else $error("p_align_r7");

  p_under_sticky_r8: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (underrun && !flag_clr && !lat_load && buf_mode == 2'b10) |=> underrun)
    else $error("p_under_sticky_r8");

  p_over_sticky_r9: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (overrun && !flag_clr && !lat_load && buf_mode == 2'b10) |=> overrun)
    else $error("p_over_sticky_r9");

  p_clear_r10: assert property (@(posedge ser_clk) disable iff (!rst_n)
    flag_clr |=> (!underrun && !overrun))
    else $error("p_clear_r10");

endmodule

bind e1_elastic_fifo e1ef_checker #(.TS_W(TS_W), .BIT_W(BIT_W)) u_chk (
  .ser_clk  (ser_clk),
  .rst_n    (rrst_n_s),
  .buf_mode (buf_mode),
  .fs_dir   (fs_dir),
  .fs_in    (fs_in),
  .lat_load (lat_load),
  .flag_clr (flag_clr),
  .ser_bit  (ser_bit),
  .fs_out   (fs_out),
  .ts_idx   (ts_idx),
  .bit_idx  (bit_idx),
  .underrun (underrun),
  .overrun  (overrun)
);

// File: tb/tb_e1_elastic_fifo.sv
`timescale 1ns/1ps
module tb_e1_elastic_fifo;

  logic       line_clk = 1'b0;
  logic       ser_clk  = 1'b0;
  logic       line_bit = 1'b0;
  logic       arst_n   = 1'b0;
  logic [1:0] buf_mode = 2'b00;
  logic       lat_load = 1'b0;
  logic [4:0] lat_bytes = 5'd0;
  logic       flag_clr = 1'b0;
  logic       fs_dir   = 1'b0;
  logic       fs_in    = 1'b0;
  logic       fs_out, fs_oe, ser_bit, underrun, overrun;
  logic [4:0] ts_idx;
  logic [2:0] bit_idx;

  int  total = 0;
  int  bad   = 0;
  bit  wrun  = 1'b1;
  bit  fast  = 1'b0;
  int  wcount = 0;
  bit  hist [4096];
  logic [15:0] lfsr = 16'hACE1;
  int  cyc = 0;

  e1_elastic_fifo dut (
    .line_clk(line_clk), .line_bit(line_bit), .ser_clk(ser_clk), .arst_n(arst_n),
    .buf_mode(buf_mode), .lat_load(lat_load), .lat_bytes(lat_bytes),
    .flag_clr(flag_clr), .fs_dir(fs_dir), .fs_in(fs_in), .fs_out(fs_out),
    .fs_oe(fs_oe), .ser_bit(ser_bit), .ts_idx(ts_idx), .bit_idx(bit_idx),
    .underrun(underrun), .overrun(overrun)
  );

  // 250 MHz serial clock, offset 1 ns from the line clock
  initial begin
    #1;
    forever #2 ser_clk = ~ser_clk;
  end

  // line clock: nominal 250 MHz, can be stopped or doubled
  initial begin
    forever begin
      #(fast ? 1 : 2);
      if (wrun) line_clk = ~line_clk;
      else      line_clk = 1'b0;
    end
  end

  always @(negedge line_clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    line_bit = lfsr[0];
  end

  always @(posedge line_clk) begin
    hist[wcount % 4096] = line_bit;
    wcount++;
  end

  always @(posedge ser_clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge ser_clk);
  endtask

  task automatic load_lat(input logic [4:0] v);
    lat_bytes = v;
    lat_load  = 1'b1;
    tick(1);
    lat_load  = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  // find the delay L (write cycles) matching a 64-bit output window (R3)
  task automatic measure(output int lat);
    bit ob [64];
    int ws [64];
    for (int i = 0; i < 64; i++) begin
      @(negedge ser_clk);
      ob[i] = ser_bit;
      ws[i] = wcount;
    end
    lat = -1;
    for (int l = 1; l <= 400; l++) begin
      bit ok = 1'b1;
      for (int i = 0; i < 64; i++) begin
        if (ob[i] != hist[(ws[i] - l) % 4096]) ok = 1'b0;
      end
      if (ok) begin
        lat = l;
        break;
      end
    end
  endtask

  task automatic t_reset();
    arst_n = 1'b0;
    tick(4);
    chk(ser_bit == 1'b1, "R1", "ser_bit in reset", ser_bit, 1);
    chk({fs_out, ts_idx, bit_idx, underrun, overrun} == '0, "R1", "outputs zero in reset",
        {fs_out, ts_idx, bit_idx, underrun, overrun}, 0);
    arst_n = 1'b1;
    tick(5);
  endtask

  task automatic t_idle();
    int errs = 0;
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b11};
    for (int c = 0; c < 3; c++) begin
      buf_mode = codes[c];
      for (int i = 0; i < 200; i++) begin
        tick(1);
        if (!ser_bit || fs_out || ts_idx != 0 || bit_idx != 0 || underrun || overrun) errs++;
      end
    end
    chk(errs == 0, "R2", "idle outputs outside FIFO mode", errs, 0);
  endtask

  task automatic t_default_lat();
    int l;
    buf_mode = 2'b10;
    tick(40);
    measure(l);
    chk(l >= 32 && l <= 38, "R1", "default 4-byte latency", l, 32);
    chk(l >= 32 && l <= 38, "R3", "bit order preserved", l, 32);
    chk(!underrun && !overrun, "R3", "no flags when locked", {underrun, overrun}, 0);
  endtask

  task automatic t_depth(input logic [4:0] v, input int bytes);
    int l;
    load_lat(v);
    tick(30);
    measure(l);
    chk(l >= 8 * bytes && l <= 8 * bytes + 6, "R4", $sformatf("latency for field %0d", v),
        l, 8 * bytes);
    chk(!underrun && !overrun, "R5", "flags clear after load", {underrun, overrun}, 0);
  endtask

  task automatic t_frame_out();
    int exp_pos = 0;
    int errs = 0;
    int pulses = 0;
    fs_dir   = 1'b0;
    buf_mode = 2'b00;
    tick(3);
    buf_mode = 2'b10;
    tick(1);
    chk(fs_oe == 1'b1, "R6", "fs_oe as output", fs_oe, 1);
    chk(fs_out && ts_idx == 0 && bit_idx == 0, "R6", "first bit is frame start",
        {fs_out, ts_idx, bit_idx}, 9'h100);
    for (int i = 0; i < 600; i++) begin
      if (i > 0) tick(1);
      if ({ts_idx, bit_idx} != 8'(exp_pos)) errs++;
      if (fs_out != (exp_pos == 0)) errs++;
      if (fs_out) pulses++;
      exp_pos = (exp_pos + 1) % 256;
    end
    chk(errs == 0, "R6", "position/pulse sequence", errs, 0);
    chk(pulses == 3, "R6", "one pulse per 256 bits", pulses, 3);
  endtask

  task automatic t_frame_in();
    int errs = 0;
    fs_dir = 1'b1;
    tick(5);
    chk(fs_oe == 1'b0, "R7", "fs_oe as input", fs_oe, 0);
    tick(37);
    fs_in = 1'b1;
    tick(1);
    fs_in = 1'b0;
    chk(ts_idx == 0 && bit_idx == 0, "R7", "realigned to pulse", {ts_idx, bit_idx}, 0);
    tick(1);
    chk(ts_idx == 0 && bit_idx == 1, "R7", "count after realign", {ts_idx, bit_idx}, 1);
    tick(8);
    chk(ts_idx == 1 && bit_idx == 1, "R7", "position 9 after pulse", {ts_idx, bit_idx}, 9);
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (fs_out) errs++;
    end
    chk(errs == 0, "R7", "no output pulse in input mode", errs, 0);
    fs_dir = 1'b0;
  endtask

  task automatic t_underrun();
    int l;
    load_lat(5'd4);
    tick(40);
    chk(!underrun, "R8", "no underrun when locked", underrun, 0);
    wrun = 1'b0;
    tick(60);
    chk(underrun, "R8", "underrun after line clock stops", underrun, 1);
    fast = 1'b1;
    wrun = 1'b1;
    tick(60);
    fast = 1'b0;
    tick(10);
    chk(underrun, "R8", "underrun sticky after refill", underrun, 1);
    pulse_clr();
    chk(!underrun, "R10", "clear strobe", underrun, 0);
    tick(30);
    chk(!underrun, "R10", "stays clear", underrun, 0);
    wrun = 1'b0;
    tick(50);
    wrun = 1'b1;
    tick(20);
    chk(underrun, "R8", "underrun while pointer ahead", underrun, 1);
    load_lat(5'd4);
    chk(!underrun && !overrun, "R5", "load clears flags", {underrun, overrun}, 0);
    tick(40);
    chk(!underrun, "R5", "recentred, no underrun", underrun, 0);
    measure(l);
    chk(l >= 32 && l <= 38, "R5", "latency after recentre", l, 32);
  endtask

  task automatic t_overrun();
    load_lat(5'd0);
    tick(40);
    chk(!overrun, "R9", "no overrun at 32 bytes", overrun, 0);
    fast = 1'b1;
    tick(300);
    chk(overrun, "R9", "overrun with fast line clock", overrun, 1);
    fast = 1'b0;
    wrun = 1'b0;
    tick(300);
    wrun = 1'b1;
    tick(10);
    chk(overrun, "R9", "overrun sticky", overrun, 1);
    chk(!underrun, "R9", "no false underrun", underrun, 0);
    pulse_clr();
    chk(!overrun, "R10", "clear strobe", overrun, 0);
    tick(30);
    chk(!overrun, "R10", "stays clear", overrun, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_default_lat();
    t_depth(5'd1, 1);
    t_depth(5'd17, 17);
    t_depth(5'd0, 32);
    t_frame_out();
    t_frame_in();
    t_underrun();
    t_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule